// File: doc/BRIEF.md
# LCD Row Scan Order Sequencer

This block produces the display RAM row address that a matrix LCD driver reads and drives on each row slot of a frame. The panel has 67 pixel rows (addresses 0 to 66) and one icon row (address 67). One row-advance strobe moves the scan to the next slot. Three mode bits shape the frame:

- A mirror bit sets whether the pixel rows are counted up or down.
- A swap bit puts the icon row at the start or at the end of the frame.
- A normal/partial bit selects the full frame or a shortened one.

The mode bits take effect only when a frame starts. A mode change therefore never mixes two orderings inside one frame. When the scan wraps into a new frame, an end-of-frame pulse lasts exactly one cycle. That pulse lines up with the first slot of the new frame.

Top module: `lcd_row_scan`

## Requirements
- R1: With the mirror bit 0, the swap bit 0 and the normal bit 1, one frame is the addresses 0, 1, ..., 66 and then 67: 68 slots in all.
- R2: With the mirror bit 1, the pixel rows are counted downward, starting at 66. The icon row 67 is still visited once, separately from the pixel rows.
- R3: With the swap bit 1, the icon row 67 is the first slot of the frame, and the counted pixel rows follow it. With the swap bit 0, the icon row is the last slot.
- R4: With the normal bit 0 (partial mode), a frame has 65 slots. These are the first 64 pixel rows in the selected direction plus the icon row. With the mirror bit 0 these are rows 0..63; with the mirror bit 1 they are rows 66..3.
- R5: The address changes only on a clock edge where the advance strobe is 1. Without the strobe it holds.
- R6: An advance from the last slot wraps to the first slot of the next frame. The end-of-frame output is 1 for exactly the one cycle after that edge, and is 0 otherwise.
- R7: The mode inputs are sampled only on reset and on the wrapping advance. A change at any other time has no effect on the rest of the current frame.
- R8: Synchronous reset samples the mode inputs and places the scan on the first slot for that mode: address 0 (mirror 0), 66 (mirror 1) or 67 (swap 1). End-of-frame is 0 after reset.
- R9: The icon flag is 1 exactly when the row address is 67.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_adv | input | 1 | Advance the scan one slot |
| mode_mirror | input | 1 | 1: count pixel rows downward |
| mode_swap | input | 1 | 1: icon row first in the frame |
| mode_normal | input | 1 | 1: full frame, 0: partial frame |
| row_addr | output | 7 | Current RAM row address |
| icon_row | output | 1 | Current slot is the icon row |
| frame_end | output | 1 | One-cycle pulse at the start of a new frame |

## Verification
Every output is valid one clock edge after the stimulus that causes it:

- the new address appears after the strobe edge;
- the end-of-frame pulse appears after the wrapping edge;
- after a reset edge, the outputs show the first slot of the mode just sampled.

The bench drives its inputs on the falling edge. A behavioural model updates on the same rising edge as the design, and the three outputs are compared on the next falling edge in every cycle. Because of this, a result that comes one cycle early or one cycle late is reported as a mismatch.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef struct packed {
    logic mirror;
    logic swap;
    logic normal;
  } scan_mode_t;

  // number of slots in one frame for a given mode
  function automatic int slots_in_frame(input logic normal, input int pix, input int part);
    return (normal ? pix : part) + 1;
  endfunction

  // row address of slot `pos` for a given mode; `pix` is also the icon address
  function automatic int slot_to_row(input int pos, input scan_mode_t m,
                                     input int pix, input int part);
    int counted;
    int k;
    counted = m.normal ? pix : part;
    if (m.swap) begin
      if (pos == 0) return pix;
      k = pos - 1;
    end else begin
      if (pos == counted) return pix;
      k = pos;
    end
    return m.mirror ? (pix - 1 - k) : k;
  endfunction

endpackage

// File: rtl/lcd_scan_mode.sv
module lcd_scan_mode
  import lcd_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  scan_mode_t mode_in,
  output scan_mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (rst || load) mode_q <= mode_in;
  end

  // R7: the held mode moves only on reset or on a frame boundary
  a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mode_q));
endmodule

// File: rtl/lcd_scan_pos.sv
module lcd_scan_pos #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [PW-1:0] last_pos,
  output logic [PW-1:0] pos,
  output logic          wrap,
  output logic          eof_q
);
  assign wrap = adv && (pos == last_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      eof_q <= 1'b0;
    end else begin
      eof_q <= wrap;
      if (wrap)     pos <= '0;
      else if (adv) pos <= pos + 1'b1;
    end
  end

  // R4: the slot index never passes the last slot of the frame
  a_r4_pos_bound: assert property (@(posedge clk) disable iff (rst)
    pos <= last_pos);
  // R6: a wrap is followed by the end-of-frame pulse and slot zero
  a_r6_wrap_eof: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (eof_q && pos == '0));
  // R5: no strobe, no movement
  a_r5_pos_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pos));
endmodule

// File: rtl/lcd_scan_map.sv
module lcd_scan_map
  import lcd_scan_pkg::*;
#(
  parameter int PIX_ROWS  = 67,
  parameter int PART_ROWS = 64,
  parameter int AW        = 7,
  parameter int PW        = 7
) (
  input  logic [PW-1:0] pos,
  input  scan_mode_t    mode,
  output logic [AW-1:0] row,
  output logic          icon,
  output logic [PW-1:0] last_pos
);
  always_comb begin
    row      = AW'(slot_to_row(int'(pos), mode, PIX_ROWS, PART_ROWS));
    last_pos = PW'(slots_in_frame(mode.normal, PIX_ROWS, PART_ROWS) - 1);
    if (mode.swap) icon = (pos == '0);
    else           icon = (pos == last_pos);
  end
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int PIX_ROWS  = 67,
  parameter int PART_ROWS = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            row_adv,
  input  logic                            mode_mirror,
  input  logic                            mode_swap,
  input  logic                            mode_normal,
  output logic [$clog2(PIX_ROWS+1)-1:0]   row_addr,
  output logic                            icon_row,
  output logic                            frame_end
);
  localparam int AW = $clog2(PIX_ROWS + 1);
  localparam int PW = $clog2(PIX_ROWS + 1);
  localparam logic [AW-1:0] ICON_ADDR = AW'(PIX_ROWS);

  scan_mode_t      mode_in, mode_q;
  logic [PW-1:0]   pos, last_pos;
  logic            frame_wrap;

  assign mode_in = '{mirror: mode_mirror, swap: mode_swap, normal: mode_normal};

  lcd_scan_mode i_mode (
    .clk(clk), .rst(rst), .load(frame_wrap), .mode_in(mode_in), .mode_q(mode_q)
  );

  lcd_scan_pos #(.PW(PW)) i_pos (
    .clk(clk), .rst(rst), .adv(row_adv), .last_pos(last_pos),
    .pos(pos), .wrap(frame_wrap), .eof_q(frame_end)
  );

  lcd_scan_map #(.PIX_ROWS(PIX_ROWS), .PART_ROWS(PART_ROWS), .AW(AW), .PW(PW)) i_map (
    .pos(pos), .mode(mode_q), .row(row_addr), .icon(icon_row), .last_pos(last_pos)
  );

  // R9: flag and address agree
  a_r9_icon_addr: assert property (@(posedge clk) disable iff (rst)
    icon_row == (row_addr == ICON_ADDR));
  // R3: with swap the new frame opens on the icon row
  a_r3_swap_first: assert property (@(posedge clk) disable iff (rst)
    (frame_end && mode_q.swap) |-> icon_row);
  // R1: without swap the wrapping slot is the icon row
  a_r1_icon_last: assert property (@(posedge clk) disable iff (rst)
    (frame_wrap && !mode_q.swap) |-> icon_row);
  // R6: end-of-frame never lasts two cycles
  a_r6_eof_single: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);
endmodule

// File: tb/test_lcd_row_scan.sv
module test_lcd_row_scan;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_adv = 1'b0;
  logic mode_mirror = 1'b0, mode_swap = 1'b0, mode_normal = 1'b1;
  logic [6:0] row_addr;
  logic icon_row, frame_end;

  always #2.5 clk = ~clk;

  lcd_row_scan i_lcd_row_scan (
    .clk(clk), .rst(rst), .row_adv(row_adv), .mode_mirror(mode_mirror),
    .mode_swap(mode_swap), .mode_normal(mode_normal),
    .row_addr(row_addr), .icon_row(icon_row), .frame_end(frame_end)
  );

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R8";

  // behavioural model
  int frame_q[$];
  int m_idx = 0;
  bit m_eof = 1'b0;

  task automatic build_frame(input bit mir, input bit swp, input bit nrm);
    int n;
    frame_q.delete();
    n = nrm ? 67 : 64;
    if (swp) frame_q.push_back(67);
    for (int i = 0; i < n; i++) frame_q.push_back(mir ? 66 - i : i);
    if (!swp) frame_q.push_back(67);
  endtask

  always @(posedge clk) begin
    cycles++;
    m_eof = 1'b0;
    if (rst) begin
      m_idx = 0;
      build_frame(mode_mirror, mode_swap, mode_normal);
    end else if (row_adv) begin
      if (m_idx == frame_q.size() - 1) begin
        m_idx = 0;
        m_eof = 1'b1;
        build_frame(mode_mirror, mode_swap, mode_normal);
      end else begin
        m_idx++;
      end
    end
  end

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      check("row_addr", row_addr, frame_q[m_idx]);
      check("icon_row R9", icon_row, frame_q[m_idx] == 67);
      check("frame_end R6", frame_end, m_eof);
    end
  end

  task automatic set_mode(input bit mir, input bit swp, input bit nrm);
    mode_mirror = mir; mode_swap = swp; mode_normal = nrm;
  endtask

  task automatic do_reset(input bit mir, input bit swp, input bit nrm, input int first);
    @(negedge clk);
    set_mode(mir, swp, nrm);
    rst = 1'b1; row_adv = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R8";
    check("reset row", row_addr, first);
    check("reset icon", icon_row, first == 67);
    check("reset eof", frame_end, 0);
  endtask

  task automatic run(input int n, input string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); row_adv = 1'b1;
    end
    @(negedge clk); row_adv = 1'b0;
  endtask

  initial begin
    do_reset(0, 0, 1, 0);
    run(68 * 2, "R1");
    do_reset(1, 0, 1, 66);
    run(68 * 2, "R2");
    do_reset(0, 1, 1, 67);
    run(68 * 2, "R3");
    do_reset(1, 1, 0, 67);
    run(65 * 2, "R4");
    do_reset(0, 0, 0, 0);
    run(65 * 2, "R4");
    // R5: sparse strobes with holds between
    tag = "R5";
    for (int i = 0; i < 150; i++) begin
      @(negedge clk); row_adv = (i % 3 == 0);
    end
    @(negedge clk); row_adv = 1'b0;
    // R7: mode change mid-frame takes effect only after the wrap
    do_reset(0, 0, 1, 0);
    run(20, "R7");
    set_mode(1, 1, 0);
    run(48 + 65 + 10, "R7");
    set_mode(0, 1, 1);
    run(30, "R7");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule